// File: doc/BRIEF.md
# Tagged Receive Queue

This block is the receive-side buffer of a serial port. The character receiver on one side pushes each completed byte into it, together with three per-character condition bits: parity mismatch, bad stop bit and line break. The host on the other side pops them one at a time. The byte and flags of the oldest character are shown at the read port before it is popped, so the host can inspect the error condition and then remove the entry.

The queue tracks its fill level and compares it with one of four selectable trigger thresholds. The comparison drives an interrupt request. A separate DMA request uses the same threshold but holds once raised, so a DMA engine can drain the queue completely. A write that finds no room is dropped and leaves a sticky overflow flag. The host clears this flag with a status-read strobe.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the queue is empty: level is 0, and rxRdy, irqReq, dmaReq and overflow are all 0.
- R2: Characters leave in the order they arrived. Each entry keeps its byte and its three flags (parity, framing, break) together. The oldest entry's byte and flags are on rdData/rdParErr/rdFrmErr/rdBrk whenever the queue is not empty, before rdPop is applied.
- R3: level equals the number of stored entries, 0 to DEPTH (64 by default), and updates on the clock edge that accepts a push or pop. A push and a pop in the same cycle leave the level unchanged.
- R4: A write while the queue holds DEPTH entries and no pop is applied in that cycle is discarded: level and the stored contents are unchanged. A write to a full queue in a cycle that also pops is accepted.
- R5: rdPop on an empty queue has no effect on level or on any output.
- R6: overflow sets on the edge after a discarded write and stays set until the edge after statusRead is high. If a discard and statusRead coincide, overflow stays set.
- R7: irqReq is high exactly when level >= the trigger threshold. trigSel codes: 0 selects 1, 1 selects DEPTH/4 (16), 2 selects DEPTH/2 (32), 3 selects DEPTH-4 (60).
- R8: dmaReq rises on the edge where level becomes >= the threshold, and stays high while entries remain, even below the threshold. It clears on the edge where the queue becomes empty.
- R9: rxRdy is high exactly when the queue holds at least one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Receiver presents a character this cycle |
| wrData | input | 8 | Received byte |
| wrParErr | input | 1 | Parity mismatch flag for this character |
| wrFrmErr | input | 1 | Bad stop bit flag for this character |
| wrBrk | input | 1 | Line break flag for this character |
| rdPop | input | 1 | Host removes the oldest entry |
| statusRead | input | 1 | Host read of status, clears overflow |
| trigSel | input | 2 | Trigger threshold select |
| rdData | output | 8 | Byte of the oldest entry |
| rdParErr | output | 1 | Parity flag of the oldest entry |
| rdFrmErr | output | 1 | Framing flag of the oldest entry |
| rdBrk | output | 1 | Break flag of the oldest entry |
| level | output | 7 | Number of stored entries |
| rxRdy | output | 1 | At least one entry stored |
| irqReq | output | 1 | Level at or above threshold |
| dmaReq | output | 1 | DMA drain request with hold until empty |
| overflow | output | 1 | Sticky dropped-character flag |

## Verification
The hardest state to reach from the ports is a completely full queue, with pointers that have wrapped, receiving a write with and without a pop in the same cycle. Only there do the discard rule and the full-queue push-through differ. The stimulus fills the queue to its limit under each of the four thresholds and then pushes extra characters. It pushes and pops together at full, then drains past the threshold to empty. A bench-side model tracks every entry, so each cycle checks the head, level, interrupt, DMA hold and overflow.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frmErr;
    logic              parErr;
    logic [BYTE_W-1:0] data;
  } rxq_entry_t;

  typedef struct packed {
    logic push;
    logic pop;
  } rxq_strobe_t;

  typedef enum logic [1:0] {
    TRIG_ONE       = 2'd0,
    TRIG_QUARTER   = 2'd1,
    TRIG_HALF      = 2'd2,
    TRIG_NEAR_FULL = 2'd3
  } trig_sel_e;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             rdPop,
  input  logic             statusRead,
  input  logic [1:0]       trigSel,
  output rxq_strobe_t      strb,
  output logic [CNT_W-1:0] level,
  output logic             rxRdy,
  output logic             irqReq,
  output logic             dmaReq,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_LVL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TRIG_LO   = CNT_W'(1);
  localparam logic [CNT_W-1:0] TRIG_QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] TRIG_MID  = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TRIG_HIGH = CNT_W'(DEPTH - 4);

  logic [CNT_W-1:0] count, countNext, trigLevel;
  logic isFull, isEmpty, popEn, pushEn, dropEn, dmaNext;

  assign isFull  = (count == FULL_LVL);
  assign isEmpty = (count == '0);
  assign popEn   = rdPop && !isEmpty;
  assign pushEn  = wrValid && (!isFull || popEn);
  assign dropEn  = wrValid && !pushEn;

  assign strb.push = pushEn;
  assign strb.pop  = popEn;

  always_comb begin
    unique case (trig_sel_e'(trigSel))
      TRIG_ONE:       trigLevel = TRIG_LO;
      TRIG_QUARTER:   trigLevel = TRIG_QTR;
      TRIG_HALF:      trigLevel = TRIG_MID;
      default:        trigLevel = TRIG_HIGH;
    endcase
  end

  always_comb begin
    unique case ({pushEn, popEn})
      2'b10:   countNext = count + CNT_W'(1);
      2'b01:   countNext = count - CNT_W'(1);
      default: countNext = count;
    endcase
  end

  always_comb begin
    if (countNext == '0)
      dmaNext = 1'b0;
    else if (countNext >= trigLevel)
      dmaNext = 1'b1;
    else
      dmaNext = dmaReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      dmaReq   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      count  <= countNext;
      dmaReq <= dmaNext;
      if (dropEn)
        overflow <= 1'b1;
      else if (statusRead)
        overflow <= 1'b0;
    end
  end

  assign level  = count;
  assign rxRdy  = !isEmpty;
  assign irqReq = (count >= trigLevel);

  // R3: the level never exceeds the storage size
  a_r3_level_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_LVL);

  // R4: a write into a full queue without a pop leaves the level alone
  a_r4_drop_keeps_level: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && isFull && !rdPop) |=> (count == FULL_LVL));

  // R6: a discarded write is always followed by the sticky flag
  a_r6_drop_flags: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && isFull && !rdPop) |=> overflow);

  // R5: popping an empty queue with no write keeps it empty
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && isEmpty && !wrValid) |=> isEmpty);

  // R8: the DMA request only drops when the queue has drained
  a_r8_dma_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dmaReq) |-> isEmpty);
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  rxq_strobe_t strb,
  input  rxq_entry_t  wrEntry,
  output rxq_entry_t  headEntry
);
  rxq_entry_t mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrPtrNext, rdPtrNext;

  generate
    if (DEPTH == (1 << PTR_W)) begin : g_pow2
      assign wrPtrNext = wrPtr + PTR_W'(1);
      assign rdPtrNext = rdPtr + PTR_W'(1);
    end else begin : g_wrap
      assign wrPtrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtrNext;
      if (strb.pop)  rdPtr <= rdPtrNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push)
      mem[wrPtr] <= wrEntry;
  end

  assign headEntry = mem[rdPtr];

  // R2: an accepted character lands intact in the slot it was aimed at
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (mem[$past(wrPtr)] == $past(wrEntry)));
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrParErr,
  input  logic              wrFrmErr,
  input  logic              wrBrk,
  input  logic              rdPop,
  input  logic              statusRead,
  input  logic [1:0]        trigSel,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdParErr,
  output logic              rdFrmErr,
  output logic              rdBrk,
  output logic [CNT_W-1:0]  level,
  output logic              rxRdy,
  output logic              irqReq,
  output logic              dmaReq,
  output logic              overflow
);
  rxq_strobe_t strb;
  rxq_entry_t  wrEntry, headEntry;

  assign wrEntry = '{brk: wrBrk, frmErr: wrFrmErr, parErr: wrParErr, data: wrData};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdPop(rdPop),
    .statusRead(statusRead), .trigSel(trigSel), .strb(strb),
    .level(level), .rxRdy(rxRdy), .irqReq(irqReq), .dmaReq(dmaReq),
    .overflow(overflow)
  );

  rxq_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrEntry(wrEntry),
    .headEntry(headEntry)
  );

  assign rdData   = headEntry.data;
  assign rdParErr = headEntry.parErr;
  assign rdFrmErr = headEntry.frmErr;
  assign rdBrk    = headEntry.brk;
endmodule

// File: tb/tb_rx_tag_fifo.sv
module tb_rx_tag_fifo;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, wrParErr = 0, wrFrmErr = 0, wrBrk = 0;
  logic rdPop = 0, statusRead = 0;
  logic [7:0] wrData = '0;
  logic [1:0] trigSel = '0;
  logic [7:0] rdData;
  logic rdParErr, rdFrmErr, rdBrk, rxRdy, irqReq, dmaReq, overflow;
  logic [6:0] level;

  int nChecks = 0, nFails = 0;
  logic [10:0] mQ [DEPTH];
  int mHead = 0, mCount = 0;
  bit mOvf = 0, mDma = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rx_tag_fifo dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .wrParErr(wrParErr), .wrFrmErr(wrFrmErr), .wrBrk(wrBrk),
    .rdPop(rdPop), .statusRead(statusRead), .trigSel(trigSel),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdBrk(rdBrk),
    .level(level), .rxRdy(rxRdy), .irqReq(irqReq), .dmaReq(dmaReq),
    .overflow(overflow)
  );

  function automatic int trigOf(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return DEPTH / 4;
      2'd2: return DEPTH / 2;
      default: return DEPTH - 4;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk("R3 level", level, mCount);
    chk("R9 rxRdy", rxRdy, mCount != 0);
    chk("R7 irqReq", irqReq, mCount >= trigOf(trigSel));
    chk("R8 dmaReq", dmaReq, mDma);
    chk("R6 overflow", overflow, mOvf);
    if (mCount != 0)
      chk("R2 head entry", {rdBrk, rdFrmErr, rdParErr, rdData}, mQ[mHead]);
  endtask

  // one cycle: inputs driven at the negedge, result checked at the next negedge
  task automatic cyc(input bit w, input logic [10:0] e, input bit p, input bit sr);
    bit popOk, pushOk;
    int oldCount;
    wrValid = w; {wrBrk, wrFrmErr, wrParErr, wrData} = e;
    rdPop = p; statusRead = sr;
    @(posedge clk);
    oldCount = mCount;
    popOk  = p && (oldCount > 0);
    pushOk = w && ((oldCount < DEPTH) || popOk);
    if (pushOk) mQ[(mHead + oldCount) % DEPTH] = e;
    if (popOk) begin mHead = (mHead + 1) % DEPTH; mCount--; end
    if (pushOk) mCount++;
    if (w && !pushOk) mOvf = 1;
    else if (sr) mOvf = 0;
    if (mCount == 0) mDma = 0;
    else if (mCount >= trigOf(trigSel)) mDma = 1;
    @(negedge clk);
    wrValid = 0; rdPop = 0; statusRead = 0;
    checkAll();
  endtask

  function automatic logic [10:0] pat(input int i, input int t);
    return 11'((i * 37 + t * 11 + 5) & 11'h7ff);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 level", level, 0);
    chk("R1 rxRdy", rxRdy, 0);
    chk("R1 irqReq", irqReq, 0);
    chk("R1 dmaReq", dmaReq, 0);
    chk("R1 overflow", overflow, 0);
    // R5: pop on empty ignored
    cyc(0, '0, 1, 0);
    chk("R5 empty pop level", level, 0);
    for (int t = 0; t < 4; t++) begin
      trigSel = 2'(t);
      @(negedge clk);
      // fill past full: R3, R7, R8 along the way, R4 at the end
      for (int i = 0; i < DEPTH + 3; i++) cyc(1, pat(i, t), 0, 0);
      chk("R4 level held at full", level, DEPTH);
      chk("R6 overflow after drop", overflow, 1);
      // R4: write plus pop at full is accepted
      cyc(1, pat(500, t), 1, 0);
      chk("R4 push-through level", level, DEPTH);
      // R6: clear collides with a drop, then plain clear
      cyc(1, pat(501, t), 0, 1);
      chk("R6 set wins", overflow, 1);
      cyc(0, '0, 0, 1);
      chk("R6 cleared", overflow, 0);
      // R3: simultaneous push/pop mid-level, then drain to empty
      for (int i = 0; i < DEPTH / 2; i++) cyc(0, '0, 1, 0);
      for (int i = 0; i < 5; i++) cyc(1, pat(600 + i, t), 1, 0);
      while (mCount > 0) cyc(0, '0, 1, 0);
      chk("R8 dma cleared at empty", dmaReq, 0);
      cyc(0, '0, 1, 0);
      chk("R5 empty pop again", level, 0);
    end
    done = 1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected done", cycles);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule